// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Core

This block drives three inverter legs from one symmetric up/down time base. Each leg gets a high-side and a low-side signal. The two are complementary, centred on the middle of the switching period, and separated by a programmable dead interval. A configuration port set holds the half-period, the dead time, the sync pulse width, the update-mode bit and one duty value per phase. Each item is written through its own write strobe into a shadow register. The time base copies the shadow values into its working set only at defined load points.

A periodic sync pulse and a one-cycle interrupt strobe mark the start of every period. A synchronous shutdown input silences all outputs at once and parks the time base. When shutdown is released, a fresh period starts immediately and uses whatever is held in the shadow registers.

Top module: `tri_pwm_core`

## Requirements
- R1: While `rst` is high, all outputs are low. Reset restores these defaults: half-period 64, dead time 0, sync width 1, single-update mode, all duties 0. With the defaults, every low-side output is held high and every high-side output is low.
- R2: The counter counts 0 up to H-1, holds H-1 for one more cycle while turning round, then counts down to 0. One period is therefore 2×H clock cycles. The half-period H is loaded only at the first cycle of a period, and a programmed value of 0 acts as 1.
- R3: Let D' = min(duty, H) and W = max(D' − dead, 0). A high-side output is high exactly while the counter is at or above H − W. That gives 2×W cycles per period, centred on the turn-round.
- R4: A low-side output is high exactly while the counter is below max(H − D' − dead, 0). High and low of one phase are never high together. Without clamping, the gap between one side turning off and the other turning on is 2×dead cycles.
- R5: With the mode bit at 0 (single update), duty and dead time are loaded at period start only. With the mode bit at 1 (double update), they are also loaded at the turn-round. The mode bit and the sync width are loaded at period start only.
- R6: `sync_o` is high during the first max(width, 1) cycles of each period, and never past the up-counting half.
- R7: `sync_irq_o` is a one-cycle strobe in the first cycle of every sync pulse.
- R8: In any cycle that samples `shdn` high, all six phase outputs, `sync_o` and `sync_irq_o` are low after that edge, and the counter restarts. The first cycle sampling `shdn` low begins a new period at once, with settings taken from the shadow registers.
- R9: Outputs are registered. They reflect the counter value and working settings of the previous cycle, and a register write never changes an output before the next load point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| shdn | input | 1 | Synchronous shutdown reset from the protection logic |
| wr_half | input | 1 | Write strobe for the half-period shadow |
| half_din | input | 16 | Half-period value in clock cycles |
| wr_dead | input | 1 | Write strobe for the dead-time shadow |
| dead_din | input | 10 | Dead time in counts |
| wr_syncw | input | 1 | Write strobe for the sync-width shadow |
| syncw_din | input | 8 | Sync pulse width in cycles |
| wr_mode | input | 1 | Write strobe for the update-mode shadow |
| mode_din | input | 1 | 0 single update, 1 double update |
| wr_duty | input | 3 | One write strobe per phase duty shadow (bit 0 phase A) |
| duty_din | input | 16 | Duty value shared by the three duty strobes |
| hi_o | output | 3 | High-side phase outputs (bit 0 phase A) |
| lo_o | output | 3 | Low-side phase outputs (bit 0 phase A) |
| sync_o | output | 1 | Period-start sync pulse |
| sync_irq_o | output | 1 | One-cycle interrupt strobe per sync pulse |

## Verification
The bench goes after duties above the half-period, duties below the dead time, and a dead time of zero. An error in clamping there would show as a pulse wider than the period or as a wrapped, near-full-width pulse. It rewrites a duty and the half-period in the middle of a period, in both update modes. A design with the wrong load point would change the pulse in the wrong half or would stretch one half of the period. It also programs a half-period of 0 and sync widths of 0 and above the half-period, where a bad design would stall, drop the pulse or run the sync into the down half. Finally it drops shutdown in the middle of a period and expects a fresh period, with freshly written settings, to start on the very next cycle.

// File: rtl/tri_pwm_pkg.sv
`timescale 1ns/1ps
package tri_pwm_pkg;
  localparam int PWM_CNT_W = 16;
  localparam int PWM_DT_W  = 10;
  localparam int PWM_SW_W  = 8;
  localparam int PWM_NPH   = 3;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } tri_pwm_dir_e;
endpackage

// File: rtl/tri_pwm_tbase.sv
`timescale 1ns/1ps
module tri_pwm_tbase
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W = PWM_CNT_W,
  parameter int SW_W  = PWM_SW_W
) (
  input  logic             clk,
  input  logic             hold,
  input  logic [CNT_W-1:0] half_a,
  input  logic [SW_W-1:0]  syncw_a,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_dn,
  output logic             at_end,
  output logic             at_mid,
  output logic             sync_q,
  output logic             irq_q
);
  localparam int CW = (CNT_W > SW_W) ? CNT_W : SW_W;

  tri_pwm_dir_e     dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CW-1:0]    cnt_x;
  logic [CW-1:0]    sw_x;
  logic             in_sync;
  logic             first;

  assign cnt    = cnt_q;
  assign dir_dn = (dir_q == DIR_DN);
  assign at_end = (dir_q == DIR_DN) && (cnt_q == '0);
  assign at_mid = (dir_q == DIR_UP) && (cnt_q == half_a - 1'b1);

  assign cnt_x   = CW'(cnt_q);
  assign sw_x    = (syncw_a == '0) ? CW'(1) : CW'(syncw_a);
  assign in_sync = (dir_q == DIR_UP) && (cnt_x < sw_x);
  assign first   = (dir_q == DIR_UP) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (hold) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (at_end) begin
      dir_q <= DIR_UP;
    end else if (at_mid) begin
      dir_q <= DIR_DN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      sync_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= in_sync;
      irq_q  <= first;
    end
  end
endmodule

// File: rtl/tri_pwm_regs.sv
`timescale 1ns/1ps
module tri_pwm_regs
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W     = PWM_CNT_W,
  parameter int DT_W      = PWM_DT_W,
  parameter int SW_W      = PWM_SW_W,
  parameter int NPH       = PWM_NPH,
  parameter int DEF_HALF  = 64,
  parameter int DEF_DEAD  = 0,
  parameter int DEF_SYNCW = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shdn,
  input  logic                      at_end,
  input  logic                      at_mid,
  input  logic                      wr_half,
  input  logic [CNT_W-1:0]          half_din,
  input  logic                      wr_dead,
  input  logic [DT_W-1:0]           dead_din,
  input  logic                      wr_syncw,
  input  logic [SW_W-1:0]           syncw_din,
  input  logic                      wr_mode,
  input  logic                      mode_din,
  input  logic [NPH-1:0]            wr_duty,
  input  logic [CNT_W-1:0]          duty_din,
  output logic [CNT_W-1:0]          half_a,
  output logic [DT_W-1:0]           dead_a,
  output logic [SW_W-1:0]           syncw_a,
  output logic                      dbl_a,
  output logic [NPH-1:0][CNT_W-1:0] duty_a
);
  localparam logic [CNT_W-1:0] HALF_RST  = (DEF_HALF == 0) ? CNT_W'(1) : CNT_W'(DEF_HALF);
  localparam logic [DT_W-1:0]  DEAD_RST  = DT_W'(DEF_DEAD);
  localparam logic [SW_W-1:0]  SYNCW_RST = SW_W'(DEF_SYNCW);

  logic [CNT_W-1:0] half_s;
  logic [DT_W-1:0]  dead_s;
  logic [SW_W-1:0]  syncw_s;
  logic             dbl_s;
  logic [CNT_W-1:0] half_ld;
  logic             ld_all;
  logic             ld_mid;

  assign ld_all  = shdn | at_end;
  assign ld_mid  = at_mid & dbl_a;
  assign half_ld = (half_s == '0) ? CNT_W'(1) : half_s;

  // shadow copies written by the configuration strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      half_s  <= HALF_RST;
      dead_s  <= DEAD_RST;
      syncw_s <= SYNCW_RST;
      dbl_s   <= 1'b0;
    end else begin
      if (wr_half)  half_s  <= half_din;
      if (wr_dead)  dead_s  <= dead_din;
      if (wr_syncw) syncw_s <= syncw_din;
      if (wr_mode)  dbl_s   <= mode_din;
    end
  end

  // working set used by the time base and comparators
  always_ff @(posedge clk) begin
    if (rst) begin
      half_a  <= HALF_RST;
      dead_a  <= DEAD_RST;
      syncw_a <= SYNCW_RST;
      dbl_a   <= 1'b0;
    end else if (ld_all) begin
      half_a  <= half_ld;
      dead_a  <= dead_s;
      syncw_a <= syncw_s;
      dbl_a   <= dbl_s;
    end else if (ld_mid) begin
      dead_a  <= dead_s;
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_duty
    logic [CNT_W-1:0] duty_s;

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_s <= '0;
      end else if (wr_duty[g]) begin
        duty_s <= duty_din;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_a[g] <= '0;
      end else if (ld_all || ld_mid) begin
        duty_a[g] <= duty_s;
      end
    end
  end
endmodule

// File: rtl/tri_pwm_phase.sv
`timescale 1ns/1ps
module tri_pwm_phase
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W = PWM_CNT_W,
  parameter int DT_W  = PWM_DT_W
) (
  input  logic             clk,
  input  logic             kill,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] half_a,
  input  logic [CNT_W-1:0] duty_a,
  input  logic [DT_W-1:0]  dead_a,
  output logic             hi_q,
  output logic             lo_q
);
  logic [CNT_W-1:0] dead_x;
  logic [CNT_W-1:0] duty_c;
  logic [CNT_W-1:0] comp_c;
  logic [CNT_W-1:0] hi_w;
  logic [CNT_W-1:0] lo_w;
  logic             hi_n;
  logic             lo_n;

  assign dead_x = CNT_W'(dead_a);
  assign duty_c = (duty_a > half_a) ? half_a : duty_a;
  assign comp_c = half_a - duty_c;
  assign hi_w   = (duty_c > dead_x) ? (duty_c - dead_x) : '0;
  assign lo_w   = (comp_c > dead_x) ? (comp_c - dead_x) : '0;
  assign hi_n   = (cnt >= (half_a - hi_w));
  assign lo_n   = (cnt < lo_w);

  always_ff @(posedge clk) begin
    if (kill) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end
endmodule

// File: rtl/tri_pwm_core.sv
`timescale 1ns/1ps
module tri_pwm_core
  import tri_pwm_pkg::*;
#(
  parameter int CNT_W     = PWM_CNT_W,
  parameter int DT_W      = PWM_DT_W,
  parameter int SW_W      = PWM_SW_W,
  parameter int NPH       = PWM_NPH,
  parameter int DEF_HALF  = 64,
  parameter int DEF_DEAD  = 0,
  parameter int DEF_SYNCW = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shdn,
  input  logic             wr_half,
  input  logic [CNT_W-1:0] half_din,
  input  logic             wr_dead,
  input  logic [DT_W-1:0]  dead_din,
  input  logic             wr_syncw,
  input  logic [SW_W-1:0]  syncw_din,
  input  logic             wr_mode,
  input  logic             mode_din,
  input  logic [NPH-1:0]   wr_duty,
  input  logic [CNT_W-1:0] duty_din,
  output logic [NPH-1:0]   hi_o,
  output logic [NPH-1:0]   lo_o,
  output logic             sync_o,
  output logic             sync_irq_o
);
  logic                      hold;
  logic [CNT_W-1:0]          tb_cnt;
  logic                      tb_dn;
  logic                      at_end;
  logic                      at_mid;
  logic [CNT_W-1:0]          half_a;
  logic [DT_W-1:0]           dead_a;
  logic [SW_W-1:0]           syncw_a;
  logic                      dbl_a;
  logic [NPH-1:0][CNT_W-1:0] duty_a;

  assign hold = rst | shdn;

  tri_pwm_regs #(
    .CNT_W(CNT_W), .DT_W(DT_W), .SW_W(SW_W), .NPH(NPH),
    .DEF_HALF(DEF_HALF), .DEF_DEAD(DEF_DEAD), .DEF_SYNCW(DEF_SYNCW)
  ) u_regs (
    .clk(clk), .rst(rst), .shdn(shdn), .at_end(at_end), .at_mid(at_mid),
    .wr_half(wr_half), .half_din(half_din),
    .wr_dead(wr_dead), .dead_din(dead_din),
    .wr_syncw(wr_syncw), .syncw_din(syncw_din),
    .wr_mode(wr_mode), .mode_din(mode_din),
    .wr_duty(wr_duty), .duty_din(duty_din),
    .half_a(half_a), .dead_a(dead_a), .syncw_a(syncw_a),
    .dbl_a(dbl_a), .duty_a(duty_a)
  );

  tri_pwm_tbase #(.CNT_W(CNT_W), .SW_W(SW_W)) u_tbase (
    .clk(clk), .hold(hold), .half_a(half_a), .syncw_a(syncw_a),
    .cnt(tb_cnt), .dir_dn(tb_dn), .at_end(at_end), .at_mid(at_mid),
    .sync_q(sync_o), .irq_q(sync_irq_o)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    tri_pwm_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
      .clk(clk), .kill(hold), .cnt(tb_cnt), .half_a(half_a),
      .duty_a(duty_a[p]), .dead_a(dead_a),
      .hi_q(hi_o[p]), .lo_q(lo_o[p])
    );
  end
endmodule

// File: rtl/tri_pwm_core_chk.sv
`timescale 1ns/1ps
module tri_pwm_core_chk #(
  parameter int CNT_W = 16,
  parameter int NPH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             shdn,
  input logic [NPH-1:0]   hi_o,
  input logic [NPH-1:0]   lo_o,
  input logic             sync_o,
  input logic             sync_irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_dn,
  input logic [CNT_W-1:0] half_a
);
  assert_pair_excl_R4: assert property (@(posedge clk) disable iff (rst)
    (hi_o & lo_o) == '0);

  assert_shdn_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    shdn |=> (hi_o == '0 && lo_o == '0 && !sync_o && !sync_irq_o));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < half_a);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst || shdn)
    (!dir_dn && cnt != half_a - 1'b1) |=> (cnt == $past(cnt) + 1'b1));

  assert_turn_hold_R2: assert property (@(posedge clk) disable iff (rst || shdn)
    (!dir_dn && cnt == half_a - 1'b1) |=> (dir_dn && cnt == $past(cnt)));

  assert_irq_in_sync_R7: assert property (@(posedge clk) disable iff (rst)
    sync_irq_o |-> sync_o);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    sync_irq_o |=> !sync_irq_o);
endmodule

bind tri_pwm_core tri_pwm_core_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .shdn(shdn), .hi_o(hi_o), .lo_o(lo_o),
  .sync_o(sync_o), .sync_irq_o(sync_irq_o),
  .cnt(tb_cnt), .dir_dn(tb_dn), .half_a(half_a)
);

// File: tb/tri_pwm_core_tb.sv
`timescale 1ns/1ps
module tri_pwm_core_tb;
  localparam int CW = 16, DW = 10, SWW = 8, NP = 3;
  localparam int S_HALF = 0, S_DEAD = 1, S_SW = 2, S_MODE = 3, S_DUTY = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1, shdn = 1'b0;
  logic          wr_half = 0, wr_dead = 0, wr_syncw = 0, wr_mode = 0, mode_din = 0;
  logic [CW-1:0] half_din = '0, duty_din = '0;
  logic [DW-1:0] dead_din = '0;
  logic [SWW-1:0] syncw_din = '0;
  logic [NP-1:0] wr_duty = '0;
  logic [NP-1:0] hi_o, lo_o;
  logic          sync_o, sync_irq_o;

  int n_chk = 0, n_fail = 0, n_print = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_pwm_core u_dut (
    .clk(clk), .rst(rst), .shdn(shdn),
    .wr_half(wr_half), .half_din(half_din), .wr_dead(wr_dead), .dead_din(dead_din),
    .wr_syncw(wr_syncw), .syncw_din(syncw_din), .wr_mode(wr_mode), .mode_din(mode_din),
    .wr_duty(wr_duty), .duty_din(duty_din),
    .hi_o(hi_o), .lo_o(lo_o), .sync_o(sync_o), .sync_irq_o(sync_irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      if (n_print < 40) begin
        n_print++;
        $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct packed {
    logic [NP-1:0] hi;
    logic [NP-1:0] lo;
    logic          sy;
    logic          irq;
    logic          sd;
  } exp_t;
  exp_t sb_q[$];

  int m_cnt = 0; bit m_dn = 0;
  int sh_half = 64, sh_dead = 0, sh_sw = 1; bit sh_dbl = 0;
  int a_half = 64, a_dead = 0, a_sw = 1; bit a_dbl = 0;
  int sh_duty[NP] = '{0, 0, 0};
  int a_duty[NP]  = '{0, 0, 0};

  function automatic int hi_width(input int d, input int dt, input int h);
    int dc = (d > h) ? h : d;
    return (dc > dt) ? dc - dt : 0;
  endfunction

  function automatic int lo_width(input int d, input int dt, input int h);
    int dc = (d > h) ? h : d;
    return (h - dc > dt) ? h - dc - dt : 0;
  endfunction

  always @(posedge clk) begin : model
    exp_t e;
    e = '0;
    if (rst) begin
      m_cnt = 0; m_dn = 0;
      sh_half = 64; sh_dead = 0; sh_sw = 1; sh_dbl = 0;
      a_half = 64; a_dead = 0; a_sw = 1; a_dbl = 0;
      for (int p = 0; p < NP; p++) begin sh_duty[p] = 0; a_duty[p] = 0; end
    end else begin
      e.sd = shdn;
      if (!shdn) begin
        for (int p = 0; p < NP; p++) begin
          e.hi[p] = (m_cnt >= a_half - hi_width(a_duty[p], a_dead, a_half));
          e.lo[p] = (m_cnt < lo_width(a_duty[p], a_dead, a_half));
        end
        e.sy  = !m_dn && (m_cnt < ((a_sw == 0) ? 1 : a_sw));
        e.irq = !m_dn && (m_cnt == 0);
      end
      if (shdn || (m_dn && m_cnt == 0)) begin
        m_cnt = 0; m_dn = 0;
        a_half = (sh_half == 0) ? 1 : sh_half;
        a_dead = sh_dead; a_sw = sh_sw; a_dbl = sh_dbl;
        for (int p = 0; p < NP; p++) a_duty[p] = sh_duty[p];
      end else if (!m_dn && m_cnt == a_half - 1) begin
        m_dn = 1;
        if (a_dbl) begin
          a_dead = sh_dead;
          for (int p = 0; p < NP; p++) a_duty[p] = sh_duty[p];
        end
      end else begin
        m_cnt = m_dn ? m_cnt - 1 : m_cnt + 1;
      end
      if (wr_half)  sh_half = int'(half_din);
      if (wr_dead)  sh_dead = int'(dead_din);
      if (wr_syncw) sh_sw   = int'(syncw_din);
      if (wr_mode)  sh_dbl  = mode_din;
      for (int p = 0; p < NP; p++) if (wr_duty[p]) sh_duty[p] = int'(duty_din);
    end
    sb_q.push_back(e);
  end

  always @(negedge clk) begin : monitor
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (e.sd) begin
        chk({hi_o, lo_o, sync_o, sync_irq_o} == '0, "R8 outputs during shutdown",
            int'({hi_o, lo_o, sync_o, sync_irq_o}), 0);
      end else begin
        chk(hi_o == e.hi, "R3 high-side pattern (R9 timing)", int'(hi_o), int'(e.hi));
        chk(lo_o == e.lo, "R4 low-side pattern (R9 timing)", int'(lo_o), int'(e.lo));
        chk(sync_o == e.sy, "R6 sync pulse", int'(sync_o), int'(e.sy));
        chk(sync_irq_o == e.irq, "R7 sync strobe", int'(sync_irq_o), int'(e.irq));
      end
    end
  end

  // ---------------- driver helpers ----------------
  task automatic wr_reg(input int sel, input int idx, input int val);
    @(posedge clk); #1;
    case (sel)
      S_HALF: begin wr_half = 1; half_din = CW'(val); end
      S_DEAD: begin wr_dead = 1; dead_din = DW'(val); end
      S_SW:   begin wr_syncw = 1; syncw_din = SWW'(val); end
      S_MODE: begin wr_mode = 1; mode_din = val[0]; end
      default: begin wr_duty[idx] = 1; duty_din = CW'(val); end
    endcase
    @(posedge clk); #1;
    wr_half = 0; wr_dead = 0; wr_syncw = 0; wr_mode = 0; wr_duty = '0;
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!sync_irq_o) @(negedge clk);
  endtask

  task automatic measure(input int h, output int nhi[NP], output int nlo[NP],
                         output int nsy, output int nirq, output int waited);
    waited = 0;
    @(negedge clk);
    while (!sync_irq_o) begin waited++; @(negedge clk); end
    nsy = 0; nirq = 0;
    for (int p = 0; p < NP; p++) begin nhi[p] = 0; nlo[p] = 0; end
    for (int i = 0; i < 2 * h; i++) begin
      if (i > 0) @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        nhi[p] += int'(hi_o[p]);
        nlo[p] += int'(lo_o[p]);
      end
      nsy  += int'(sync_o);
      nirq += int'(sync_irq_o);
    end
  endtask

  task automatic period_len(output int len);
    wait_irq();
    len = 0;
    do begin len++; @(negedge clk); end while (!sync_irq_o);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d (run hung)", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin : main
    int nh[NP], nl[NP];
    int nsy, nirq, wt, len;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({hi_o, lo_o, sync_o, sync_irq_o} == '0, "R1 outputs in reset",
        int'({hi_o, lo_o, sync_o, sync_irq_o}), 0);
    @(posedge clk); #1; rst = 0;
    repeat (5) @(negedge clk);
    chk(lo_o == 3'b111, "R1 default low side", int'(lo_o), 7);
    chk(hi_o == 3'b000, "R1 default high side", int'(hi_o), 0);
    period_len(len);
    chk(len == 128, "R1 default period", len, 128);

    // R3/R4 widths, clamping and sync
    wr_reg(S_HALF, 0, 20); wr_reg(S_DEAD, 0, 3); wr_reg(S_SW, 0, 4);
    wr_reg(S_DUTY, 0, 10); wr_reg(S_DUTY, 1, 0); wr_reg(S_DUTY, 2, 25);
    wait_irq(); wait_irq();
    measure(20, nh, nl, nsy, nirq, wt);
    chk(nh[0] == 14, "R3 phase A high width", nh[0], 14);
    chk(nl[0] == 14, "R4 phase A low width", nl[0], 14);
    chk(nh[1] == 0,  "R3 duty below dead time", nh[1], 0);
    chk(nl[1] == 34, "R4 phase B low width", nl[1], 34);
    chk(nh[2] == 34, "R3 duty above half clamped", nh[2], 34);
    chk(nl[2] == 0,  "R4 phase C low suppressed", nl[2], 0);
    chk(nsy == 4,    "R6 sync width 4", nsy, 4);
    chk(nirq == 1,   "R7 one strobe per period", nirq, 1);

    // R2 half-period written mid-period takes effect at next start
    fork
      period_len(len);
      begin wait_irq(); repeat (5) @(posedge clk); wr_reg(S_HALF, 0, 30); end
    join
    chk(len == 40, "R2 period unchanged by mid write", len, 40);
    period_len(len);
    chk(len == 60, "R2 new period after load", len, 60);
    wr_reg(S_HALF, 0, 20);
    wait_irq(); wait_irq();

    // R5 single update mode
    fork
      measure(20, nh, nl, nsy, nirq, wt);
      begin wait_irq(); repeat (3) @(posedge clk); wr_reg(S_DUTY, 0, 16); end
    join
    chk(nh[0] == 14, "R5 single mode keeps duty", nh[0], 14);
    chk(nl[0] == 14, "R5 single mode keeps low", nl[0], 14);
    measure(20, nh, nl, nsy, nirq, wt);
    chk(nh[0] == 26, "R5 single mode next period", nh[0], 26);
    chk(nl[0] == 2,  "R5 single mode next low", nl[0], 2);

    // R5 double update mode
    wr_reg(S_DUTY, 0, 10); wr_reg(S_MODE, 0, 1);
    wait_irq(); wait_irq();
    fork
      measure(20, nh, nl, nsy, nirq, wt);
      begin wait_irq(); repeat (3) @(posedge clk); wr_reg(S_DUTY, 0, 16); end
    join
    chk(nh[0] == 20, "R5 double mode midpoint load", nh[0], 20);
    chk(nl[0] == 8,  "R5 double mode low halves", nl[0], 8);
    wr_reg(S_MODE, 0, 0);

    // R6 sync width corner values
    wr_reg(S_SW, 0, 0);
    wait_irq(); wait_irq();
    measure(20, nh, nl, nsy, nirq, wt);
    chk(nsy == 1, "R6 width zero acts as one", nsy, 1);
    wr_reg(S_SW, 0, 200);
    wait_irq(); wait_irq();
    measure(20, nh, nl, nsy, nirq, wt);
    chk(nsy == 20, "R6 width limited to up half", nsy, 20);

    // R2 half-period zero
    wr_reg(S_HALF, 0, 0);
    wait_irq(); wait_irq();
    period_len(len);
    chk(len == 2, "R2 half zero acts as one", len, 2);
    wr_reg(S_HALF, 0, 20); wr_reg(S_SW, 0, 4); wr_reg(S_DUTY, 0, 10);
    wait_irq(); wait_irq();

    // R8 shutdown mid-period, new setting written while stopped
    wait_irq();
    repeat (7) @(posedge clk);
    #1 shdn = 1;
    @(negedge clk); @(negedge clk);
    chk({hi_o, lo_o, sync_o} == '0, "R8 outputs off in shutdown",
        int'({hi_o, lo_o, sync_o}), 0);
    wr_reg(S_DUTY, 0, 16);
    repeat (3) @(posedge clk);
    #1 shdn = 0;
    @(posedge clk);
    measure(20, nh, nl, nsy, nirq, wt);
    chk(wt == 0, "R8 period restarts at release", wt, 0);
    chk(nh[0] == 26, "R8 restart uses shadow duty", nh[0], 26);

    repeat (10) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule